// File: doc/BRIEF.md
# Cascadable Synchronous Up/Down Counter Stage

This block is one four-bit slice of a synchronous binary counter. It counts up or down, can be preset from a parallel data word, and can hold its value. Every state change happens on the rising clock edge, and all count bits update together on that edge. Load and the two count enables are active-low. The load is synchronous and overrides the enables.

An active-low terminal-count output lets several slices form a wider counter with no extra gating. This output is decoded combinationally from the present count, the direction and the second enable (T). The carry of a lower slice drives the T input of the next slice up. The first enable (P) is shared by all slices. An upper slice therefore advances only on the edge where every lower slice sits at its terminal value.

A synchronous active-low reset clears the count, so the state is known after power-up.

Top module: `updown_counter_stage`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `q` becomes 0. Reset has priority over every other control.
- R2: When `rst_n` is high and `load_n` is low at a rising edge, `q` takes the value of `data`, whatever `en_p_n`, `en_t_n` and `up_dn` are.
- R3: When `rst_n` and `load_n` are high, `en_p_n` and `en_t_n` are both low, and `up_dn` is 1, `q` increments by one at the edge. It wraps from 15 to 0.
- R4: Under the same enable conditions with `up_dn` at 0, `q` decrements by one at the edge. It wraps from 0 to 15.
- R5: When `rst_n` and `load_n` are high and either `en_p_n` or `en_t_n` is high, `q` keeps its value across the edge.
- R6: `carry_n` is low exactly when `en_t_n` is low and the count is at its terminal value: 15 with `up_dn`=1, or 0 with `up_dn`=0. `en_p_n` has no effect on `carry_n`.
- R7: Changes on `load_n`, `data`, `en_p_n`, `en_t_n` or `up_dn` between two rising edges never change `q` before the next edge.
- R8: Two stages, with the lower `carry_n` driving the upper `en_t_n` and with `en_p_n`, `up_dn` and `load_n` shared, act as an eight-bit synchronous up/down counter. It steps through every value in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset to zero |
| load_n | input | 1 | Synchronous active-low parallel load |
| data | input | WIDTH (4) | Preset value taken when loading |
| en_p_n | input | 1 | Active-low count enable shared across a cascade |
| en_t_n | input | 1 | Active-low count enable that also gates the carry |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| q | output | WIDTH (4) | Registered count |
| carry_n | output | 1 | Active-low terminal-count output |

## Verification
Two stages are chained into an eight-bit counter. The pair is run through a full upward sweep and a full downward sweep of all 256 values. These sweeps show that the upper slice advances only on the wrap of the lower slice, and that both wrap points are correct. Directed cases check the following:
- A load during a count overrides the enables.
- Each enable alone holds the count.
- P being high does not suppress the carry, while T being high does.
- Control pulses placed between edges leave `q` untouched.

A seeded random phase then mixes loads, holds and direction reversals. It compares `q` and both carries on every cycle with a bench model. This is what exposes priority mistakes between load and count.

// File: rtl/updown_counter_pkg.sv
package updown_counter_pkg;

    // Operation chosen for the next clock edge, after priority resolution
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2,
        OP_LOAD = 2'd3
    } count_op_e;

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import updown_counter_pkg::*;
(
    input  logic      load_n,
    input  logic      en_p_n,
    input  logic      en_t_n,
    input  logic      up_dn,
    output count_op_e op
);

    logic run;

    // Both active-low enables must be asserted for a count step
    assign run = ~en_p_n & ~en_t_n;

    always_comb begin
        if (!load_n) begin
            op = OP_LOAD;
        end else if (run) begin
            op = up_dn ? OP_INC : OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/ctr_step.sv
module ctr_step
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  count_op_e          op,
    input  logic [WIDTH-1:0]   cur,
    input  logic [WIDTH-1:0]   data,
    output logic [WIDTH-1:0]   nxt
);

    localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);

    logic [WIDTH-1:0] plus_one;
    logic [WIDTH-1:0] minus_one;

    // Modular arithmetic gives the wrap at both ends for free
    assign plus_one  = cur + UNIT;
    assign minus_one = cur - UNIT;

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = data;
            OP_INC:  nxt = plus_one;
            OP_DEC:  nxt = minus_one;
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_tc_decode.sv
module ctr_tc_decode #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             up_dn,
    input  logic             en_t_n,
    output logic             carry_n
);

    logic at_max;
    logic at_min;
    logic at_terminal;

    // Decode only the stable registered count: no intermediate states
    assign at_max      = &cur;
    assign at_min      = ~|cur;
    assign at_terminal = up_dn ? at_max : at_min;
    assign carry_n     = ~(at_terminal & ~en_t_n);

endmodule

// File: rtl/updown_counter_stage.sv
module updown_counter_stage
    import updown_counter_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] data,
    input  logic             en_p_n,
    input  logic             en_t_n,
    input  logic             up_dn,
    output logic [WIDTH-1:0] q,
    output logic             carry_n
);

    localparam logic [WIDTH-1:0] ZERO_VAL = '0;
    localparam logic [WIDTH-1:0] MAX_VAL  = '1;
    localparam logic [WIDTH-1:0] UNIT     = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } stage_state_t;

    stage_state_t     st_d, st_q;
    count_op_e        op;
    logic [WIDTH-1:0] step_val;

    ctr_op_decode u_op_decode (
        .load_n (load_n),
        .en_p_n (en_p_n),
        .en_t_n (en_t_n),
        .up_dn  (up_dn),
        .op     (op)
    );

    ctr_step #(.WIDTH(WIDTH)) u_step (
        .op   (op),
        .cur  (st_q.count),
        .data (data),
        .nxt  (step_val)
    );

    ctr_tc_decode #(.WIDTH(WIDTH)) u_tc_decode (
        .cur     (st_q.count),
        .up_dn   (up_dn),
        .en_t_n  (en_t_n),
        .carry_n (carry_n)
    );

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.count = ZERO_VAL;
        end else begin
            st_d.count = step_val;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.count;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (q == ZERO_VAL));

    // R2
    load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n |=> (q == $past(data)));

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && up_dn) |=> (q == $past(q) + UNIT));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && !en_p_n && !en_t_n && !up_dn) |=> (q == $past(q) - UNIT));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && (en_p_n || en_t_n)) |=> $stable(q));

    // R6
    carry_gated_by_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_t_n |-> carry_n);

    // R6
    carry_only_terminal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> ((up_dn && q == MAX_VAL) || (!up_dn && q == ZERO_VAL)));

endmodule

// File: tb/updown_counter_stage_tb.sv
module updown_counter_stage_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;
    localparam int WATCHDOG_CYCLES = 50000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         load_n;
    logic [7:0]   data8;
    logic         en_p_n;
    logic         en_t_n;
    logic         up_dn;
    logic [W-1:0] q_lo, q_hi;
    logic         carry_lo_n, carry_hi_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0] exp8;

    always #(CLK_PERIOD/2) clk = ~clk;

    updown_counter_stage #(.WIDTH(W)) u_dut (
        .clk (clk), .rst_n (rst_n), .load_n (load_n), .data (data8[3:0]),
        .en_p_n (en_p_n), .en_t_n (en_t_n), .up_dn (up_dn),
        .q (q_lo), .carry_n (carry_lo_n)
    );

    updown_counter_stage #(.WIDTH(W)) u_dut_hi (
        .clk (clk), .rst_n (rst_n), .load_n (load_n), .data (data8[7:4]),
        .en_p_n (en_p_n), .en_t_n (carry_lo_n), .up_dn (up_dn),
        .q (q_hi), .carry_n (carry_hi_n)
    );

    function automatic logic [7:0] next_model(logic [7:0] cur, logic ld_n,
                                              logic [7:0] d, logic p_n,
                                              logic t_n, logic dir);
        if (!ld_n)            return d;
        else if (!p_n && !t_n) return dir ? cur + 8'd1 : cur - 8'd1;
        else                  return cur;
    endfunction

    function automatic logic model_carry_lo(logic [3:0] v, logic dir, logic t_n);
        return ~(~t_n & (dir ? (v == 4'hF) : (v == 4'h0)));
    endfunction

    function automatic logic model_carry_hi(logic [7:0] v, logic dir, logic t_n);
        return ~(~t_n & (dir ? (v == 8'hFF) : (v == 8'h00)));
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        check({tag, " q"}, {q_hi, q_lo}, exp8);
        check("R6 low carry", carry_lo_n, model_carry_lo(exp8[3:0], up_dn, en_t_n));
        check("R8 cascade carry", carry_hi_n, model_carry_hi(exp8, up_dn, en_t_n));
    endtask

    // Model update from present inputs, one edge, then sample 1 time unit later
    task automatic tick(string tag);
        exp8 = next_model(exp8, load_n, data8, en_p_n, en_t_n, up_dn);
        @(posedge clk);
        #1;
        check_all(tag);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C47));
        rst_n = 1'b0; load_n = 1'b1; data8 = 8'hA5;
        en_p_n = 1'b0; en_t_n = 1'b0; up_dn = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        exp8 = 8'h00;
        check("R1 reset q", {q_hi, q_lo}, 8'h00);

        // R1: reset beats a load
        load_n = 1'b0;
        @(posedge clk); #1;
        check("R1 reset over load", {q_hi, q_lo}, 8'h00);
        load_n = 1'b1;
        rst_n = 1'b1;

        // R3 / R8: full upward sweep with wrap 255 -> 0
        up_dn = 1'b1;
        for (int i = 0; i < 258; i++) tick("R3 up sweep");

        // R4 / R8: full downward sweep with wrap 0 -> 255
        up_dn = 1'b0;
        for (int i = 0; i < 258; i++) tick("R4 down sweep");

        // R2: load mid-count, enables inactive, then active
        load_n = 1'b0; data8 = 8'h3C; en_p_n = 1'b1; en_t_n = 1'b1;
        tick("R2 load with enables off");
        data8 = 8'hC7; en_p_n = 1'b0; en_t_n = 1'b0; up_dn = 1'b1;
        tick("R2 load while counting");
        load_n = 1'b1;
        tick("R3 count after load");

        // R5: each enable alone holds
        en_p_n = 1'b1;
        repeat (3) tick("R5 hold P high");
        en_p_n = 1'b0; en_t_n = 1'b1;
        repeat (3) tick("R5 hold T high");
        en_t_n = 1'b0;

        // R6: P high does not hide the carry; T high does
        load_n = 1'b0; data8 = 8'h0F;
        tick("R2 load 0F");
        load_n = 1'b1; en_p_n = 1'b1;
        tick("R6 hold at F");
        check("R6 carry with P high", carry_lo_n, 1'b0);
        en_t_n = 1'b1;
        #1;
        check("R6 carry with T high", carry_lo_n, 1'b1);
        up_dn = 1'b0;
        en_t_n = 1'b0;
        #1;
        check("R6 no carry at F counting down", carry_lo_n, 1'b1);
        en_p_n = 1'b0;

        // R7: control pulses between edges do not touch q
        en_p_n = 1'b1;
        tick("R7 setup hold");
        #2 load_n = 1'b0; data8 = 8'h99; en_p_n = 1'b0;
        #2 check("R7 mid-cycle load", {q_hi, q_lo}, exp8);
        load_n = 1'b1; up_dn = 1'b1;
        #1 check("R7 mid-cycle count", {q_hi, q_lo}, exp8);
        en_p_n = 1'b1; up_dn = 1'b0;
        tick("R7 edge after pulses");

        // Random mix of loads, holds and direction changes
        for (int i = 0; i < 600; i++) begin
            load_n = ($urandom_range(0, 9) != 0);
            data8  = 8'($urandom);
            en_p_n = ($urandom_range(0, 3) == 0);
            en_t_n = ($urandom_range(0, 3) == 0);
            up_dn  = 1'($urandom);
            tick("R8 random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule